// File: doc/BRIEF.md
# Two-Rate Three-Color Ingress Meter

This block meters a stream of packet descriptors against two token buckets, a committed bucket and a peak bucket. Each packet is charged a token cost that depends on its length, a programmable length offset and a signed per-packet adjust term. The packet is then marked green, yellow or red, and red packets are flagged for drop. The block can meter in bytes, or in packets per second when the length term is switched off and the adjust term is set to one token.

Each bucket is described by four fields: a rate mantissa and exponent, a burst mantissa and exponent, and a time divider. A base tick comes from a clock prescaler, and its period is nominally 2 µs. On every 2^div-th tick a bucket gains (1 + M/256)·2^E tokens. The bucket level never rises above (1 + M/256)·2^E of its burst fields. All amounts are kept in units of 1/256 token. An exponent of 24 or more encodes zero, so a bucket whose burst exponent is 24 or more holds nothing and is effectively unused. The meter is color-blind. Its decision depends only on the two bucket levels and the packet cost.

Descriptors enter through a valid/ready handshake. One registered result (color and drop flag) is offered on a second valid/ready handshake and is held until it is taken.

Top module: `trtcm_policer`

## Requirements
- R1: A base tick occurs once every PRESCALE clock cycles. Each bucket's refill is applied on every 2^div-th tick, where div is the bucket's 4-bit divider. The amount added is (256+rate_man)<<rate_exp units of 1/256 token.
- R2: Bucket levels saturate at the burst cap (256+burst_man)<<burst_exp units. Both buckets are full after reset.
- R3: With len_mode=0 the packet cost is (pkt_len − len_offset)·256 + (adj_man − 256)<<adj_exp units. A result below 1 unit is raised to 1 unit, so the minimum cost is 1/256 token.
- R4: With len_mode=1, adj_man=384 and adj_exp=1, every packet costs exactly one token (256 units), whatever its length.
- R5: A rate or burst exponent of 24 or more encodes an amount of zero. A bucket with a zero cap never covers a packet, so when the peak bucket is unused no packet is yellow.
- R6: A packet is green when the committed level is at least its cost, and it is then debited from both buckets (the peak level floors at zero). It is yellow when only the peak level covers it, and only the peak bucket is debited. Otherwise it is red and neither bucket changes.
- R7: res_color encodes green as 2'b00, yellow as 2'b01 and red as 2'b10. res_drop is 1 exactly for red results.
- R8: pkt_ready is high when no result is pending or res_ready is high. While res_valid is high and res_ready is low, the result stays stable and no new packet is taken.
- R9: When a refill and a debit hit a bucket in the same cycle, both take effect: the debit is applied first, then the refill, then the cap. The color is decided on the level before that cycle's refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet descriptor valid |
| pkt_ready | output | 1 | Descriptor accepted when high with pkt_valid |
| pkt_len | input | 16 | Packet length in bytes |
| cmt_rate_man | input | 8 | Committed refill mantissa |
| cmt_rate_exp | input | 5 | Committed refill exponent |
| cmt_burst_man | input | 8 | Committed cap mantissa |
| cmt_burst_exp | input | 5 | Committed cap exponent |
| cmt_div | input | 4 | Committed refill divider (log2 ticks) |
| pk_rate_man | input | 8 | Peak refill mantissa |
| pk_rate_exp | input | 5 | Peak refill exponent |
| pk_burst_man | input | 8 | Peak cap mantissa |
| pk_burst_exp | input | 5 | Peak cap exponent |
| pk_div | input | 4 | Peak refill divider (log2 ticks) |
| len_mode | input | 1 | 1 = ignore length term (packet-rate mode) |
| len_offset | input | 16 | Bytes subtracted from the length |
| adj_man | input | 9 | Per-packet adjust mantissa |
| adj_exp | input | 5 | Per-packet adjust exponent |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken when high with res_valid |
| res_color | output | 2 | Result color |
| res_drop | output | 1 | Drop flag for the result |

## Verification
A refill and a packet debit can land on the same bucket in the same clock edge. The bench provokes this by draining the committed bucket and then counting cycles from reset release, so that a minimum-cost packet is accepted exactly on the edge where the second tick refills. The packet must come out red, because the decision sees the pre-refill level of zero. A later packet costing exactly one refill must then come out green, which shows that the refill was not lost to the debit path. Refill spacing and the cap are judged the same way: the bench sends a packet costing just more or just less than the level the refill arithmetic predicts.

// File: rtl/trtcm_pkg.sv
package trtcm_pkg;

    localparam int FRAC_W    = 8;
    localparam int MAN_W     = 8;
    localparam int EXP_W     = 5;
    localparam int ADJ_MAN_W = 9;
    localparam int DIV_W     = 4;
    localparam int LEN_W     = 16;
    localparam int LVL_W     = 34;
    localparam int ZERO_EXP  = 24;
    localparam int CALC_W    = 48;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        COL_GREEN  = 2'b00,
        COL_YELLOW = 2'b01,
        COL_RED    = 2'b10
    } color_e;

    typedef struct packed {
        logic [MAN_W-1:0] rate_man;
        logic [EXP_W-1:0] rate_exp;
        logic [MAN_W-1:0] burst_man;
        logic [EXP_W-1:0] burst_exp;
        logic [DIV_W-1:0] div;
    } bkt_cfg_t;

    // (1 + m/256) * 2^e tokens expressed in 1/256-token units
    function automatic lvl_t me_units(input logic [MAN_W-1:0] m,
                                      input logic [EXP_W-1:0] e);
        lvl_t base;
        base = lvl_t'({1'b1, m});
        if (e >= EXP_W'(ZERO_EXP))
            return '0;
        return base << e;
    endfunction

    // Per-packet charge in 1/256-token units, floored at one unit
    function automatic lvl_t pkt_cost(input logic [LEN_W-1:0]     len,
                                      input logic [LEN_W-1:0]     off,
                                      input logic                 lmode,
                                      input logic [ADJ_MAN_W-1:0] am,
                                      input logic [EXP_W-1:0]     ae);
        logic signed [CALC_W-1:0] len_t;
        logic signed [CALC_W-1:0] adj_t;
        logic signed [CALC_W-1:0] sum;
        logic signed [CALC_W-1:0] top;
        logic [EXP_W-1:0]         ae_c;
        ae_c  = (ae > EXP_W'(ZERO_EXP)) ? EXP_W'(ZERO_EXP) : ae;
        len_t = $signed(CALC_W'(len)) - $signed(CALC_W'(off));
        len_t = lmode ? '0 : (len_t <<< FRAC_W);
        adj_t = $signed(CALC_W'(am)) - $signed(CALC_W'(256));
        adj_t = adj_t <<< ae_c;
        sum   = len_t + adj_t;
        top   = $signed(CALC_W'({LVL_W{1'b1}}));
        if (sum < $signed(CALC_W'(1)))
            return lvl_t'(1);
        if (sum > top)
            return '1;
        return lvl_t'(sum);
    endfunction

endpackage

// File: rtl/trtcm_tick.sv
module trtcm_tick #(
    parameter int PRESCALE = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    // R1: base tick is a single-cycle pulse
    p_tick_single_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/trtcm_bucket.sv
module trtcm_bucket
    import trtcm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  bkt_cfg_t cfg,
    input  logic     debit_en,
    input  lvl_t     debit_amt,
    output lvl_t     level
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] span;
    logic             refill;
    lvl_t             cap;
    lvl_t             add;
    lvl_t             after_deb;
    lvl_t             level_nxt;
    logic [LVL_W:0]   sum;

    always_comb begin
        cap    = me_units(cfg.burst_man, cfg.burst_exp);
        add    = me_units(cfg.rate_man, cfg.rate_exp);
        span   = (CNT_W'(1) << cfg.div) - CNT_W'(1);
        refill = tick && (div_cnt == span);
        after_deb = level;
        if (debit_en)
            after_deb = (level > debit_amt) ? (level - debit_amt) : '0;
        sum = {1'b0, after_deb} + (refill ? {1'b0, add} : {(LVL_W+1){1'b0}});
        level_nxt = (sum > {1'b0, cap}) ? cap : sum[LVL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= cap;
            div_cnt <= '0;
        end else begin
            level <= level_nxt;
            if (tick)
                div_cnt <= refill ? '0 : (div_cnt + CNT_W'(1));
        end
    end

    // R2: a bucket never holds more than its cap
    p_level_cap_r2: assert property (@(posedge clk) disable iff (rst)
        level <= cap);

endmodule

// File: rtl/trtcm_policer.sv
module trtcm_policer
    import trtcm_pkg::*;
#(
    parameter int PRESCALE = 100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pkt_valid,
    output logic                 pkt_ready,
    input  logic [LEN_W-1:0]     pkt_len,
    input  logic [MAN_W-1:0]     cmt_rate_man,
    input  logic [EXP_W-1:0]     cmt_rate_exp,
    input  logic [MAN_W-1:0]     cmt_burst_man,
    input  logic [EXP_W-1:0]     cmt_burst_exp,
    input  logic [DIV_W-1:0]     cmt_div,
    input  logic [MAN_W-1:0]     pk_rate_man,
    input  logic [EXP_W-1:0]     pk_rate_exp,
    input  logic [MAN_W-1:0]     pk_burst_man,
    input  logic [EXP_W-1:0]     pk_burst_exp,
    input  logic [DIV_W-1:0]     pk_div,
    input  logic                 len_mode,
    input  logic [LEN_W-1:0]     len_offset,
    input  logic [ADJ_MAN_W-1:0] adj_man,
    input  logic [EXP_W-1:0]     adj_exp,
    output logic                 res_valid,
    input  logic                 res_ready,
    output logic [1:0]           res_color,
    output logic                 res_drop
);
    localparam int NB = 2;

    logic     tick;
    bkt_cfg_t cfg   [NB];
    lvl_t     lvl   [NB];
    logic     debit [NB];
    lvl_t     cost;
    logic     cmt_ok;
    logic     pk_ok;
    logic     accept;
    color_e   col;
    color_e   col_q;

    trtcm_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign cfg[0] = '{rate_man: cmt_rate_man, rate_exp: cmt_rate_exp,
                      burst_man: cmt_burst_man, burst_exp: cmt_burst_exp,
                      div: cmt_div};
    assign cfg[1] = '{rate_man: pk_rate_man, rate_exp: pk_rate_exp,
                      burst_man: pk_burst_man, burst_exp: pk_burst_exp,
                      div: pk_div};

    for (genvar g = 0; g < NB; g++) begin : g_bkt
        trtcm_bucket u_bkt (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .cfg       (cfg[g]),
            .debit_en  (debit[g]),
            .debit_amt (cost),
            .level     (lvl[g])
        );
    end

    assign pkt_ready = !res_valid || res_ready;
    assign accept    = pkt_valid && pkt_ready;

    always_comb begin
        cost   = pkt_cost(pkt_len, len_offset, len_mode, adj_man, adj_exp);
        cmt_ok = (lvl[0] >= cost);
        pk_ok  = (lvl[1] >= cost);
        if (cmt_ok)
            col = COL_GREEN;
        else if (pk_ok)
            col = COL_YELLOW;
        else
            col = COL_RED;
        debit[0] = accept && (col == COL_GREEN);
        debit[1] = accept && (col != COL_RED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            col_q     <= COL_GREEN;
            res_drop  <= 1'b0;
        end else if (accept) begin
            res_valid <= 1'b1;
            col_q     <= col;
            res_drop  <= (col == COL_RED);
        end else if (res_ready) begin
            res_valid <= 1'b0;
        end
    end

    assign res_color = col_q;

    // R7: drop flag matches a red result
    p_drop_red_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_drop == (res_color == COL_RED)));

    // R8: a stalled result stays put
    p_hold_result_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_color) && $stable(res_drop)));

    // R8: no intake while a result is stalled
    p_no_intake_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |-> !pkt_ready);

    // R5: an unused peak bucket never yields yellow
    p_no_yellow_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (pk_burst_exp >= EXP_W'(ZERO_EXP))) |-> (res_color != COL_YELLOW));

endmodule

// File: tb/trtcm_policer_tb.sv
module trtcm_policer_tb;

    localparam int PRESCALE = 100;
    localparam logic [1:0] G = 2'b00;
    localparam logic [1:0] Y = 2'b01;
    localparam logic [1:0] R = 2'b10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic        pkt_ready;
    logic [15:0] pkt_len = '0;
    logic [7:0]  cmt_rate_man = '0;
    logic [4:0]  cmt_rate_exp = 5'd24;
    logic [7:0]  cmt_burst_man = '0;
    logic [4:0]  cmt_burst_exp = 5'd10;
    logic [3:0]  cmt_div = '0;
    logic [7:0]  pk_rate_man = '0;
    logic [4:0]  pk_rate_exp = 5'd24;
    logic [7:0]  pk_burst_man = '0;
    logic [4:0]  pk_burst_exp = 5'd24;
    logic [3:0]  pk_div = '0;
    logic        len_mode = 1'b0;
    logic [15:0] len_offset = '0;
    logic [8:0]  adj_man = 9'd256;
    logic [4:0]  adj_exp = '0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic [1:0]  res_color;
    logic        res_drop;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    trtcm_policer #(.PRESCALE(PRESCALE)) u_dut (
        .clk(clk), .rst(rst),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
        .cmt_rate_man(cmt_rate_man), .cmt_rate_exp(cmt_rate_exp),
        .cmt_burst_man(cmt_burst_man), .cmt_burst_exp(cmt_burst_exp), .cmt_div(cmt_div),
        .pk_rate_man(pk_rate_man), .pk_rate_exp(pk_rate_exp),
        .pk_burst_man(pk_burst_man), .pk_burst_exp(pk_burst_exp), .pk_div(pk_div),
        .len_mode(len_mode), .len_offset(len_offset),
        .adj_man(adj_man), .adj_exp(adj_exp),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_color(res_color), .res_drop(res_drop)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input int len, input logic [1:0] ec, input string req);
        @(negedge clk);
        pkt_len   = 16'(len);
        pkt_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        check(res_valid == 1'b1, {req, " valid"}, int'(res_valid), 1);
        check(res_color == ec, {req, " color"}, int'(res_color), int'(ec));
        check(res_drop == (ec == R), {req, " drop R7"}, int'(res_drop), int'(ec == R));
    endtask

    task automatic wait_cyc(input int target);
        do @(negedge clk); while (cyc < target);
    endtask

    task automatic base_cfg();
        cmt_rate_man = 0;  cmt_rate_exp = 24; cmt_burst_man = 0; cmt_burst_exp = 10; cmt_div = 0;
        pk_rate_man  = 0;  pk_rate_exp  = 24; pk_burst_man  = 0; pk_burst_exp  = 24; pk_div  = 0;
        len_mode = 0; len_offset = 0; adj_man = 256; adj_exp = 0;
    endtask

    task automatic t_reset_state();
        base_cfg();
        do_reset();
        @(negedge clk);
        check(res_valid == 1'b0, "R8 reset res_valid", int'(res_valid), 0);
        check(pkt_ready == 1'b1, "R8 reset pkt_ready", int'(pkt_ready), 1);
    endtask

    // R6 byte mode, committed cap 768, peak cap 2048, no refill
    task automatic t_three_color();
        base_cfg();
        cmt_burst_man = 128; cmt_burst_exp = 9;
        pk_burst_exp  = 11;
        do_reset();
        send(400, G, "R2 R6 full start green");
        send(400, Y, "R6 peak-only yellow");
        send(400, Y, "R6 yellow 2");
        send(400, Y, "R6 yellow 3");
        send(400, Y, "R6 yellow 4");
        send(400, R, "R6 red no cover");
        send(300, G, "R6 red left levels untouched");
        send(68,  G, "R6 exact-cover green");
        send(1,   R, "R6 both empty red");
    endtask

    // R4 packet-rate mode, 4-token committed bucket
    task automatic t_pps();
        base_cfg();
        cmt_burst_exp = 2;
        len_mode = 1; adj_man = 384; adj_exp = 1;
        do_reset();
        send(1500, G, "R4 pkt 1");
        send(64,   G, "R4 pkt 2");
        send(9000, G, "R4 pkt 3");
        send(1,    G, "R4 pkt 4");
        send(1500, R, "R4 fifth red R5");
    endtask

    // R3 offset and negative adjust (-4 tokens), 16-token bucket
    task automatic t_cost();
        base_cfg();
        cmt_burst_exp = 4;
        len_offset = 100; adj_man = 0; adj_exp = 2;
        do_reset();
        send(110, G, "R3 cost 6");
        send(110, G, "R3 cost 6 again");
        send(110, R, "R3 cost 6 over 4");
        send(50,  G, "R3 negative floored to 1/256");
        send(109, R, "R3 cost 5 over 1023/256");
        send(107, G, "R3 cost 3");
        send(104, G, "R3 zero floored");
        send(105, R, "R3 one token over 254/256");
    endtask

    // R1 R2 R9 refill: 64 tokens every 2 ticks, cap 256
    task automatic t_refill();
        base_cfg();
        cmt_burst_exp = 8; cmt_rate_exp = 6; cmt_div = 1;
        do_reset();
        send(256, G, "R2 full at reset");
        send(1,   R, "R1 drained before refill");
        wait_cyc(198);
        send(0,   R, "R9 decided on pre-refill level");
        wait_cyc(300);
        send(64,  G, "R9 R1 refill kept alongside debit");
        send(1,   R, "R1 exactly one refill");
        wait_cyc(1900);
        send(256, G, "R2 capped after many refills");
        send(1,   R, "R2 cap not exceeded");
        wait_cyc(2110);
        send(65,  R, "R1 divider spacing");
        send(64,  G, "R1 one refill per two ticks");
    endtask

    // R8 backpressure
    task automatic t_backpressure();
        base_cfg();
        cmt_burst_man = 128; cmt_burst_exp = 9;
        pk_burst_exp  = 11;
        do_reset();
        res_ready = 1'b0;
        send(400, G, "R8 first result");
        pkt_len   = 16'd3000;
        pkt_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(pkt_ready == 1'b0, "R8 stalled ready", int'(pkt_ready), 0);
            check(res_valid && res_color == G, "R8 held color", int'(res_color), int'(G));
        end
        res_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        check(res_valid && res_color == R, "R8 next result", int'(res_color), int'(R));
        check(res_drop == 1'b1, "R8 R7 drop", int'(res_drop), 1);
        @(negedge clk);
        check(res_valid == 1'b0, "R8 consumed", int'(res_valid), 0);
    endtask

    initial begin
        t_reset_state();
        t_three_color();
        t_pps();
        t_cost();
        t_refill();
        t_backpressure();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule